// File: doc/BRIEF.md
# I3C Target Address Header Responder

This block is the front end of an I3C/I2C target. It catches the nine-bit address header that follows a Start or a Restart. It samples SDA on each SCL rising edge, collecting seven address bits (most significant first) and then the R/W bit. It compares the address with the broadcast address, the target's static address and its dynamic address. Which of these can match depends on the operating mode. From that match and the transaction type, it decides whether to acknowledge. The only drive it makes on the bus is an open-drain pull-down during the ninth bit.

SCL edges reach the block as single-cycle strobes (`sclRise`, `sclFall`) in the system clock domain. Start and Restart also arrive as strobes. The block reports four things:
- whether the current header can be arbitrated (it followed a Start) or not (it followed a Restart);
- the captured R/W bit for private transfers;
- the kind of match;
- a one-cycle pulse that consumes a single-use acknowledge token.

Top module: `i3c_target_addr_responder`

## Requirements
- R1: After a Start or Restart, the block samples `sdaIn` on eight `sclRise` strobes, taking the address MSB first and then R/W. It pulls SDA low only from the first `sclFall` after the eighth rise until the `sclFall` after the ninth rise, and only when it acknowledges.
- R2: `arbitrable` is 1 from the cycle after a `startSeen` strobe and 0 from the cycle after a `restartSeen` strobe. It holds its value otherwise.
- R3: `opMode` selects the match rules. 0 (I2C) matches only `staticAddr`. 1 (SDR) matches only `dynAddr`, and only when `dynValid` = 1. 2 (static SDR) matches both. 3 matches nothing. The broadcast address 7'h7E matches in modes 1 and 2. `matchType` reads 0 none, 1 broadcast, 2 static, 3 dynamic. The order of precedence is broadcast, then dynamic, then static.
- R4: A broadcast header is always acknowledged, except for a read during an address-assignment phase (`daaPhase` = 1).
- R5: A private read (R/W = 1, static or dynamic match) is acknowledged only when `txNotEmpty` = 1 and also either `ackHoldEn` = 0 or `ackToken` = 1.
- R6: A private write (R/W = 0) is acknowledged when `ackHoldEn` = 0, or when `ackHoldEn` = 1 and `ackToken` = 1. It is not acknowledged when `ackHoldEn` = 1 and `ackToken` = 0. `txNotEmpty` has no effect.
- R7: A broadcast read during `daaPhase` is never acknowledged while `dynValid` = 1. Otherwise it is acknowledged when `hotJoinCap` = 0, or when `hotJoinCap` = 1 and `hotJoinReq` = 1.
- R8: When an acknowledge uses the token path (`ackHoldEn` = 1, `ackToken` = 1, private match), `ackTokenClr` goes high for exactly one cycle, in the cycle after the eighth rise.
- R9: `rnwOut` takes the R/W bit on a static or dynamic match and keeps its previous value otherwise.
- R10: An address that matches nothing, including the Hot-Join address 7'h02, leaves SDA released and gives `matchType` = 0.
- R11: A Start or Restart during a header, or during its ACK bit, releases SDA, clears `matchType` and restarts capture from the first address bit.
- R12: After reset, `sdaPullLow`, `rnwOut`, `matchType`, `arbitrable` and `ackTokenClr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclRise | input | 1 | Strobe: SCL rising edge seen |
| sclFall | input | 1 | Strobe: SCL falling edge seen |
| sdaIn | input | 1 | Sampled SDA level |
| startSeen | input | 1 | Strobe: Start condition |
| restartSeen | input | 1 | Strobe: Restart condition |
| opMode | input | 2 | Operating mode (R3) |
| staticAddr | input | 7 | Static address |
| dynAddr | input | 7 | Dynamic address |
| dynValid | input | 1 | Dynamic address assigned |
| ackHoldEn | input | 1 | Private headers need a token to be acknowledged |
| ackToken | input | 1 | Single-use acknowledge token available |
| txNotEmpty | input | 1 | Transmit data ready |
| daaPhase | input | 1 | Address-assignment phase active |
| hotJoinCap | input | 1 | Hot-Join capability enabled |
| hotJoinReq | input | 1 | Hot-Join already requested |
| sdaPullLow | output | 1 | Open-drain SDA pull-down enable |
| rnwOut | output | 1 | Captured R/W of last private match |
| matchType | output | 2 | Match kind of last header |
| arbitrable | output | 1 | Current header followed a Start |
| ackTokenClr | output | 1 | One-cycle pulse consuming the token |

## Verification
The bench builds the block with the default 7-bit address width and the default broadcast and Hot-Join codes. At that width the real bus codes, 7'h7E and 7'h02, can be driven directly, and the counter's last-bit decode lands on the true eighth edge. Against that build, a vector table covers every mode against static, dynamic, broadcast and stray addresses, and the read, write and assignment acknowledge rules with the token on and off. Directed cases cover reset, a Restart that cuts into a half-captured header, and a Start during the ACK bit.

// File: rtl/addr_hdr_pkg.sv
package addr_hdr_pkg;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] BCAST_ADDR   = 7'h7E;
  localparam logic [ADDR_W-1:0] HOTJOIN_ADDR = 7'h02;

  typedef enum logic [1:0] {
    MODE_I2C        = 2'd0,
    MODE_SDR        = 2'd1,
    MODE_SDR_STATIC = 2'd2,
    MODE_OFF        = 2'd3
  } opMode_e;

  typedef enum logic [1:0] {
    MT_NONE   = 2'd0,
    MT_BCAST  = 2'd1,
    MT_STATIC = 2'd2,
    MT_DYN    = 2'd3
  } match_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearHdr;
    logic shiftBit;
    logic captureHdr;
  } hdrStrobe_t;
endpackage

// File: rtl/addr_hdr_datapath.sv
module addr_hdr_datapath
  import addr_hdr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] BCAST = BCAST_ADDR,
  parameter logic [AW-1:0] HJ    = HOTJOIN_ADDR
) (
  input  logic          clk,
  input  logic          rstN,
  input  hdrStrobe_t    strobe,
  input  logic          sdaIn,
  input  logic          startSeen,
  input  logic          restartSeen,
  input  logic [1:0]    opMode,
  input  logic [AW-1:0] staticAddr,
  input  logic [AW-1:0] dynAddr,
  input  logic          dynValid,
  output logic          lastBit,
  output match_e        matchNow,
  output match_e        matchType,
  output logic          rnwOut,
  output logic          arbitrable
);
  localparam int HDR_BITS = AW + 1;
  localparam int CNT_W    = $clog2(HDR_BITS);

  logic [AW-1:0]    shiftReg;
  logic [CNT_W-1:0] bitCnt;

  assign lastBit = (bitCnt == CNT_W'(HDR_BITS - 1));

  // Match is evaluated when shiftReg holds the address and sdaIn carries R/W
  logic sdrOn, staticOn, bcastHit, dynHit, statHit, hjHit;
  always_comb begin
    sdrOn    = (opMode == MODE_SDR) || (opMode == MODE_SDR_STATIC);
    staticOn = (opMode == MODE_I2C) || (opMode == MODE_SDR_STATIC);
    hjHit    = (shiftReg == HJ);
    bcastHit = sdrOn && (shiftReg == BCAST);
    dynHit   = sdrOn && dynValid && (shiftReg == dynAddr);
    statHit  = staticOn && (shiftReg == staticAddr);
    if (hjHit)         matchNow = MT_NONE;
    else if (bcastHit) matchNow = MT_BCAST;
    else if (dynHit)   matchNow = MT_DYN;
    else if (statHit)  matchNow = MT_STATIC;
    else               matchNow = MT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      matchType <= MT_NONE;
      rnwOut    <= 1'b0;
    end else if (strobe.clearHdr) begin
      bitCnt    <= '0;
      matchType <= MT_NONE;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[AW-2:0], sdaIn};
      bitCnt   <= bitCnt + 1'b1;
      if (strobe.captureHdr) begin
        matchType <= matchNow;
        if (matchNow == MT_STATIC || matchNow == MT_DYN) rnwOut <= sdaIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            arbitrable <= 1'b0;
    else if (startSeen)   arbitrable <= 1'b1;
    else if (restartSeen) arbitrable <= 1'b0;
  end
endmodule

// File: rtl/addr_hdr_control.sv
module addr_hdr_control
  import addr_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSeen,
  input  logic       restartSeen,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaIn,
  input  logic       lastBit,
  input  match_e     matchNow,
  input  logic       dynValid,
  input  logic       ackHoldEn,
  input  logic       ackToken,
  input  logic       txNotEmpty,
  input  logic       daaPhase,
  input  logic       hotJoinCap,
  input  logic       hotJoinReq,
  output hdrStrobe_t strobe,
  output logic       sdaPullLow,
  output logic       ackTokenClr
);
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_WAIT, S_ACK} state_e;
  state_e state, stateNext;

  logic hdrEvent, ackNow, privHit, useToken, ackLatched;

  assign hdrEvent          = startSeen | restartSeen;
  assign strobe.clearHdr   = hdrEvent;
  assign strobe.shiftBit   = (state == S_SHIFT) && sclRise && !hdrEvent;
  assign strobe.captureHdr = strobe.shiftBit && lastBit;

  // sdaIn is the R/W bit at capture
  always_comb begin
    privHit = (matchNow == MT_STATIC) || (matchNow == MT_DYN);
    unique case (matchNow)
      MT_BCAST:  ackNow = (daaPhase && sdaIn) ?
                          (!dynValid && (!hotJoinCap || hotJoinReq)) : 1'b1;
      MT_STATIC,
      MT_DYN:    ackNow = (!ackHoldEn || ackToken) && (!sdaIn || txNotEmpty);
      default:   ackNow = 1'b0;
    endcase
    useToken = privHit && ackHoldEn && ackNow;
  end

  always_comb begin
    stateNext = state;
    if (hdrEvent) stateNext = S_SHIFT;
    else begin
      unique case (state)
        S_SHIFT: if (strobe.captureHdr) stateNext = S_WAIT;
        S_WAIT:  if (sclFall) stateNext = S_ACK;
        S_ACK:   if (sclFall) stateNext = S_IDLE;
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      ackLatched  <= 1'b0;
      ackTokenClr <= 1'b0;
    end else begin
      state       <= stateNext;
      ackTokenClr <= strobe.captureHdr && useToken;
      if (strobe.captureHdr) ackLatched <= ackNow;
      else if (hdrEvent)     ackLatched <= 1'b0;
    end
  end

  assign sdaPullLow = (state == S_ACK) && ackLatched;
endmodule

// File: rtl/i3c_target_addr_responder.sv
module i3c_target_addr_responder
  import addr_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaIn,
  input  logic       startSeen,
  input  logic       restartSeen,
  input  logic [1:0] opMode,
  input  logic [6:0] staticAddr,
  input  logic [6:0] dynAddr,
  input  logic       dynValid,
  input  logic       ackHoldEn,
  input  logic       ackToken,
  input  logic       txNotEmpty,
  input  logic       daaPhase,
  input  logic       hotJoinCap,
  input  logic       hotJoinReq,
  output logic       sdaPullLow,
  output logic       rnwOut,
  output logic [1:0] matchType,
  output logic       arbitrable,
  output logic       ackTokenClr
);
  hdrStrobe_t strobe;
  match_e     matchNow, matchReg;
  logic       lastBit;

  addr_hdr_datapath #(.AW(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaIn(sdaIn),
    .startSeen(startSeen), .restartSeen(restartSeen), .opMode(opMode),
    .staticAddr(staticAddr), .dynAddr(dynAddr), .dynValid(dynValid),
    .lastBit(lastBit), .matchNow(matchNow), .matchType(matchReg),
    .rnwOut(rnwOut), .arbitrable(arbitrable)
  );

  addr_hdr_control u_ctl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .restartSeen(restartSeen),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .lastBit(lastBit),
    .matchNow(matchNow), .dynValid(dynValid), .ackHoldEn(ackHoldEn),
    .ackToken(ackToken), .txNotEmpty(txNotEmpty), .daaPhase(daaPhase),
    .hotJoinCap(hotJoinCap), .hotJoinReq(hotJoinReq), .strobe(strobe),
    .sdaPullLow(sdaPullLow), .ackTokenClr(ackTokenClr)
  );

  assign matchType = matchReg;
endmodule

// File: rtl/addr_hdr_checker.sv
module addr_hdr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startSeen,
  input logic       restartSeen,
  input logic       ackHoldEn,
  input logic       ackToken,
  input logic       sdaPullLow,
  input logic [1:0] matchType,
  input logic       arbitrable,
  input logic       ackTokenClr
);
  AST_ARB_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> arbitrable);                                   // R2
  AST_ARB_CLR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (restartSeen && !startSeen) |=> !arbitrable);                // R2
  AST_PULL_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> (matchType != 2'd0));                         // R10
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ackTokenClr |=> !ackTokenClr);                               // R8
  AST_CLR_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rstN)
    ackTokenClr |-> $past(ackHoldEn && ackToken));               // R8
  AST_CLR_PRIVATE: assert property (@(posedge clk) disable iff (!rstN)
    ackTokenClr |-> matchType[1]);                               // R8
  AST_EVENT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen || restartSeen) |=> (!sdaPullLow && matchType == 2'd0)); // R11
endmodule

bind i3c_target_addr_responder addr_hdr_checker u_chk (
  .clk(clk), .rstN(rstN), .startSeen(startSeen), .restartSeen(restartSeen),
  .ackHoldEn(ackHoldEn), .ackToken(ackToken), .sdaPullLow(sdaPullLow),
  .matchType(matchType), .arbitrable(arbitrable), .ackTokenClr(ackTokenClr)
);

// File: tb/tb_i3c_target_addr_responder.sv
module tb_i3c_target_addr_responder;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclRise = 0, sclFall = 0, sdaIn = 0, startSeen = 0, restartSeen = 0;
  logic [1:0] opMode = 0;
  logic [6:0] staticAddr = 7'h21, dynAddr = 7'h35;
  logic dynValid = 0, ackHoldEn = 0, ackToken = 0, txNotEmpty = 0;
  logic daaPhase = 0, hotJoinCap = 0, hotJoinReq = 0;
  logic sdaPullLow, rnwOut, arbitrable, ackTokenClr;
  logic [1:0] matchType;

  int total = 0, bad = 0;
  logic expRnw = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  i3c_target_addr_responder dut (.*);

  typedef struct packed {
    logic       isRestart;
    logic [6:0] addr;
    logic       rnw;
    logic [1:0] mode;
    logic       hold, token, txne, daa, hjcap, hjreq, dynv;
    logic       expAck;
    logic [1:0] expMatch;
    logic       expClr;
    logic [2:0] kind;   // 0:R3 1:R4 2:R5 3:R6 4:R7 5:R10
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    //  rs addr  rw md ho tk tx da hc hr dv ack mt clr kind
    '{1'b0,7'h7E,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,1'b0,3'd1}, // R4 bcast write
    '{1'b1,7'h21,1'b1,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b0,3'd2}, // R5 read, tx ready
    '{1'b0,7'h21,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,1'b0,3'd2}, // R5 read, tx empty
    '{1'b1,7'h21,1'b1,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b1,3'd2}, // R5 R8 token read
    '{1'b0,7'h21,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,1'b0,3'd2}, // R5 hold, no token
    '{1'b0,7'h21,1'b1,2'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,1'b0,3'd2}, // R5 token but tx empty
    '{1'b1,7'h21,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b0,3'd3}, // R6 write free
    '{1'b0,7'h21,1'b0,2'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b1,3'd3}, // R6 R8 token write
    '{1'b0,7'h21,1'b0,2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,1'b0,3'd3}, // R6 hold, no token
    '{1'b1,7'h35,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd3,1'b0,3'd0}, // R3 SDR dyn
    '{1'b0,7'h21,1'b1,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,3'd0}, // R3 SDR ignores static
    '{1'b0,7'h35,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,3'd0}, // R3 dyn not valid
    '{1'b0,7'h35,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,3'd0}, // R3 I2C ignores dyn
    '{1'b1,7'h35,1'b1,2'd2,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'd3,1'b0,3'd0}, // R3 both: dyn
    '{1'b0,7'h21,1'b0,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd2,1'b0,3'd0}, // R3 both: static
    '{1'b0,7'h7E,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,3'd0}, // R3 I2C no bcast
    '{1'b0,7'h21,1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,3'd0}, // R3 mode off
    '{1'b1,7'h7E,1'b1,2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd1,1'b0,3'd4}, // R7 no HJ cap
    '{1'b1,7'h7E,1'b1,2'd1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd1,1'b0,3'd4}, // R7 HJ not requested
    '{1'b1,7'h7E,1'b1,2'd1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,2'd1,1'b0,3'd4}, // R7 HJ requested
    '{1'b1,7'h7E,1'b1,2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,3'd4}, // R7 already has dyn
    '{1'b0,7'h02,1'b0,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,3'd5}  // R10 Hot-Join addr
  };

  function automatic string reqName(input logic [2:0] k);
    case (k)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hdrEvent(input logic isRestart);
    @(negedge clk);
    if (isRestart) restartSeen = 1'b1; else startSeen = 1'b1;
    @(negedge clk);
    restartSeen = 1'b0; startSeen = 1'b0;
  endtask

  task automatic rise(input logic v);
    @(negedge clk); sdaIn = v; sclRise = 1'b1;
    @(negedge clk); sclRise = 1'b0;
  endtask

  task automatic fall();
    @(negedge clk); sclFall = 1'b1;
    @(negedge clk); sclFall = 1'b0;
  endtask

  // Eight rises with falls between; stops right after the eighth rise
  task automatic sendHdrBits(input logic [6:0] a, input logic rw);
    for (int i = 6; i >= 0; i--) begin
      rise(a[i]);
      fall();
    end
    rise(rw);
  endtask

  initial begin
    #(PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R12: reset state
    #(PERIOD * 2);
    @(negedge clk);
    check("R12", "sdaPullLow", sdaPullLow, 0);
    check("R12", "matchType", matchType, 0);
    check("R12", "rnwOut", rnwOut, 0);
    check("R12", "arbitrable", arbitrable, 0);
    check("R12", "ackTokenClr", ackTokenClr, 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      string rq = reqName(t.kind);
      opMode = t.mode; ackHoldEn = t.hold; ackToken = t.token; txNotEmpty = t.txne;
      daaPhase = t.daa; hotJoinCap = t.hjcap; hotJoinReq = t.hjreq; dynValid = t.dynv;
      hdrEvent(t.isRestart);
      check("R2", "arbitrable", arbitrable, t.isRestart ? 0 : 1);
      sendHdrBits(t.addr, t.rnw);
      if (t.expMatch == 2'd2 || t.expMatch == 2'd3) expRnw = t.rnw;
      check(rq, "matchType", matchType, t.expMatch);
      check("R8", "ackTokenClr", ackTokenClr, t.expClr);
      check("R9", "rnwOut", rnwOut, expRnw);
      check("R1", "no pull before fall", sdaPullLow, 0);
      @(negedge clk);
      check("R8", "clr single cycle", ackTokenClr, 0);
      fall();
      check(rq, "ack pull", sdaPullLow, t.expAck);
      rise(1'b0);
      check("R1", "pull held over 9th rise", sdaPullLow, t.expAck);
      fall();
      check("R1", "released after ack", sdaPullLow, 0);
    end

    // R11: Restart cuts a half-captured header, then a clean capture follows
    opMode = 2'd0; ackHoldEn = 0; txNotEmpty = 0; daaPhase = 0; dynValid = 0;
    hdrEvent(1'b0);
    for (int i = 0; i < 4; i++) begin rise(1'b1); fall(); end
    hdrEvent(1'b1);
    check("R11", "arbitrable after restart", arbitrable, 0);
    sendHdrBits(7'h21, 1'b0);
    check("R11", "matchType after restart", matchType, 2);
    fall();
    check("R11", "ack after restart", sdaPullLow, 1);
    // R11: Start during the ACK bit releases SDA at once
    hdrEvent(1'b0);
    check("R11", "release on start in ack", sdaPullLow, 0);
    check("R11", "match cleared", matchType, 0);
    // R10: unmatched address with static-SDR mode
    opMode = 2'd2;
    sendHdrBits(7'h55, 1'b0);
    check("R10", "stray match", matchType, 0);
    fall();
    check("R10", "stray released", sdaPullLow, 0);
    rise(1'b0); fall();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule